// File: doc/BRIEF.md
# Receive Mailbox Placement Engine

This block chooses the mailbox that stores each frame delivered by a CAN receive path. Every mailbox has a software-written filter word and mask word. An incoming frame is compared against all enabled mailboxes at once. It is stored in the highest-numbered mailbox that accepts it and is free to take it. That mailbox's pending bit is then raised so that software can collect the frame.

When a mailbox's protect bit is set and the mailbox still holds an unread frame, the mailbox is passed over and the search moves to the next lower mailbox. This means a bank of mailboxes with identical filters fills from the top down, and frames can be read back in order of arrival. If no accepting mailbox can take the frame, the frame is discarded. The lost bit of the highest accepting mailbox is then set and the lost interrupt is raised.

Frames arrive on a valid/ready stream. `rx_ready` is low during reset and is high from the first clock edge after reset, because the block accepts one frame on every cycle. A frame is taken on a rising edge where both `rx_valid` and `rx_ready` are high. All fields must be held stable while `rx_valid` is high. Configuration and write-one-to-clear actions use a plain one-cycle write port. Mailbox contents are read through a combinational read port.

Top module: `rx_mailbox_alloc`

## Requirements
- R1: An accepted frame is stored in the highest-numbered mailbox that is enabled, passes its filter, and is not blocked. The pending bit of that mailbox is set on the same clock edge.
- R2: The stored identifier word has bit 31 = 1 for an extended frame with the ID in bits 28:0. For a standard frame, bit 31 = 0 and the ID is in bits 28:18. The stored control word holds the DLC in bits 3:0 and RTR in bit 4. The low and high data words are stored unchanged.
- R3: Writing select 2 clears each pending bit whose write-data bit is 1. A write-data bit of 0 leaves that pending bit unchanged.
- R4: A mailbox whose protect bit (select 1) is 1 and whose pending bit is 1 is skipped, and the frame goes to the next lower eligible mailbox.
- R5: If every accepting mailbox is blocked, the frame is discarded. Mailbox contents and pending bits do not change, and the lost bit of the highest accepting mailbox is set.
- R6: If a mailbox whose protect bit is 0 still holds an unread frame, a new frame overwrites it and the lost bit of that mailbox is set.
- R7: When filter bit 30 is 1, a 1 in the mask word (select 5) makes the matching frame-word bit a don't-care. When filter bit 30 is 0, bits 31 and 28:0 must match exactly, so the frame format must also match.
- R8: A mailbox whose enable bit (select 0) is 0 never receives a frame. It rejoins the search as soon as its enable bit is set again.
- R9: `irq_lost` is high while any lost bit is set. Writing select 3 clears each lost bit whose write-data bit is 1.
- R10: A frame that no enabled mailbox accepts changes no state.
- R11: If a frame is stored into a mailbox in the same cycle that its pending bit is cleared, the pending bit ends up set.
- R12: After reset, the pending bits, lost bits and `irq_lost` are all 0, and `rx_ready` is 1 from the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Frame offered |
| rx_ready | output | 1 | Frame can be accepted |
| rx_ext | input | 1 | Extended-format frame |
| rx_id | input | 29 | Identifier (standard frames use bits 10:0) |
| rx_rtr | input | 1 | Remote request flag |
| rx_dlc | input | 4 | Data length code |
| rx_dlo | input | 32 | Data bytes 0..3, byte 0 in bits 31:24 |
| rx_dhi | input | 32 | Data bytes 4..7 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | 0 enable, 1 protect, 2 pending clear, 3 lost clear, 4 filter word, 5 mask word |
| wr_mb | input | MBW | Mailbox index for selects 4 and 5 |
| wr_data | input | 32 | Write data |
| rd_mb | input | MBW | Mailbox index to read |
| rd_id | output | 32 | Stored identifier word |
| rd_ctrl | output | 32 | Stored control word |
| rd_dlo | output | 32 | Stored low data word |
| rd_dhi | output | 32 | Stored high data word |
| pending | output | NUM_MB | Pending bits |
| lost | output | NUM_MB | Lost bits |
| irq_lost | output | 1 | Lost-frame interrupt request |

## Verification
The bench fills a bank of catch-all mailboxes until it is full. A design that searched upward, or that ignored the protect bit, would place the second frame in the wrong slot or overwrite the first one. The bench then discards a frame with every accepting mailbox blocked. A design that stored the frame anyway, or that flagged the wrong mailbox, would show changed contents or a wrong lost vector. It also checks the following cases:
- Masked and unmasked filters, including a frame that differs from a filter only in format.
- A mailbox that is disabled and then re-enabled.
- A pending clear that lands in the same cycle as a store. A design that gave the clear priority would leave a stored frame with its pending bit low.

// File: rtl/rx_mailbox_pkg.sv
package rx_mailbox_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE   = 3'd0,
    SEL_PROTECT  = 3'd1,
    SEL_PEND_CLR = 3'd2,
    SEL_LOST_CLR = 3'd3,
    SEL_FILTER   = 3'd4,
    SEL_MASK     = 3'd5
  } wsel_e;

  // identifier word bits that take part in a comparison: format flag and ID field
  localparam logic [31:0] CMP_BITS = 32'h9FFF_FFFF;
  localparam int          MASK_EN_BIT = 30;
endpackage

// File: rtl/mb_accept.sv
module mb_accept
  import rx_mailbox_pkg::*;
(
  input  logic [31:0] filt_word,
  input  logic [31:0] mask_word,
  input  logic [31:0] frame_word,
  output logic        hit
);
  logic [31:0] care;

  always_comb begin
    care = filt_word[MASK_EN_BIT] ? ~mask_word : '1;
    hit  = (((filt_word ^ frame_word) & care & CMP_BITS) == 32'd0);
  end
endmodule

// File: rtl/hi_pick.sv
module hi_pick #(
  parameter  int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rx_mailbox_alloc.sv
module rx_mailbox_alloc
  import rx_mailbox_pkg::*;
#(
  parameter  int NUM_MB = 32,
  localparam int MBW    = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_ext,
  input  logic [28:0]       rx_id,
  input  logic              rx_rtr,
  input  logic [3:0]        rx_dlc,
  input  logic [31:0]       rx_dlo,
  input  logic [31:0]       rx_dhi,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [MBW-1:0]    wr_mb,
  input  logic [31:0]       wr_data,
  input  logic [MBW-1:0]    rd_mb,
  output logic [31:0]       rd_id,
  output logic [31:0]       rd_ctrl,
  output logic [31:0]       rd_dlo,
  output logic [31:0]       rd_dhi,
  output logic [NUM_MB-1:0] pending,
  output logic [NUM_MB-1:0] lost,
  output logic              irq_lost
);
  logic [NUM_MB-1:0] enable_q, protect_q, pending_q, lost_q;
  logic [31:0] filt_q [NUM_MB];
  logic [31:0] mask_q [NUM_MB];
  logic [31:0] sid_q  [NUM_MB];
  logic [4:0]  ctl_q  [NUM_MB];
  logic [31:0] dlo_q  [NUM_MB];
  logic [31:0] dhi_q  [NUM_MB];
  logic        ready_q;

  wsel_e       sel;
  logic [31:0] frame_word;
  logic [NUM_MB-1:0] hit_vec, match_vec, ok_vec;
  logic        ok_found, match_found;
  logic [MBW-1:0] ok_idx, match_idx;
  logic        fire, take, drop_full;
  logic [NUM_MB-1:0] clr_pend, clr_lost, set_pend, set_lost;

  assign sel        = wsel_e'(wr_sel);
  assign frame_word = rx_ext ? {1'b1, 2'b00, rx_id} : {3'b000, rx_id[10:0], 18'd0};

  generate
    for (genvar g = 0; g < NUM_MB; g++) begin : g_filt
      mb_accept u_acc (
        .filt_word  (filt_q[g]),
        .mask_word  (mask_q[g]),
        .frame_word (frame_word),
        .hit        (hit_vec[g])
      );
    end
  endgenerate

  assign match_vec = hit_vec & enable_q;
  assign ok_vec    = match_vec & ~(pending_q & protect_q);

  hi_pick #(.N(NUM_MB)) u_pick_ok (.req(ok_vec), .found(ok_found), .idx(ok_idx));
  hi_pick #(.N(NUM_MB)) u_pick_match (.req(match_vec), .found(match_found), .idx(match_idx));

  always_comb begin
    fire      = rx_valid && ready_q;
    take      = fire && ok_found;
    drop_full = fire && !ok_found && match_found;
    clr_pend  = (wr_en && sel == SEL_PEND_CLR) ? wr_data[NUM_MB-1:0] : '0;
    clr_lost  = (wr_en && sel == SEL_LOST_CLR) ? wr_data[NUM_MB-1:0] : '0;
    set_pend  = '0;
    set_lost  = '0;
    if (take) begin
      set_pend[ok_idx] = 1'b1;
      if (pending_q[ok_idx]) set_lost[ok_idx] = 1'b1;
    end
    if (drop_full) set_lost[match_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      enable_q  <= '0;
      protect_q <= '0;
      pending_q <= '0;
      lost_q    <= '0;
      for (int i = 0; i < NUM_MB; i++) begin
        filt_q[i] <= '0;
        mask_q[i] <= '0;
        sid_q[i]  <= '0;
        ctl_q[i]  <= '0;
        dlo_q[i]  <= '0;
        dhi_q[i]  <= '0;
      end
    end else begin
      ready_q   <= 1'b1;
      pending_q <= (pending_q & ~clr_pend) | set_pend;
      lost_q    <= (lost_q & ~clr_lost) | set_lost;
      if (wr_en && sel == SEL_ENABLE)  enable_q  <= wr_data[NUM_MB-1:0];
      if (wr_en && sel == SEL_PROTECT) protect_q <= wr_data[NUM_MB-1:0];
      if (wr_en && sel == SEL_FILTER)  filt_q[wr_mb] <= wr_data;
      if (wr_en && sel == SEL_MASK)    mask_q[wr_mb] <= wr_data;
      if (take) begin
        sid_q[ok_idx] <= frame_word;
        ctl_q[ok_idx] <= {rx_rtr, rx_dlc};
        dlo_q[ok_idx] <= rx_dlo;
        dhi_q[ok_idx] <= rx_dhi;
      end
    end
  end

  assign rx_ready = ready_q;
  assign rd_id    = sid_q[rd_mb];
  assign rd_ctrl  = {27'd0, ctl_q[rd_mb]};
  assign rd_dlo   = dlo_q[rd_mb];
  assign rd_dhi   = dhi_q[rd_mb];
  assign pending  = pending_q;
  assign lost     = lost_q;
  assign irq_lost = |lost_q;

  // R1: no eligible mailbox above the chosen one
  assert_highest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((ok_vec >> ok_idx) >> 1) == '0);
  // R1: chosen mailbox shows pending afterwards
  assert_pend_after_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pending_q[$past(ok_idx)]);
  // R4: never write into a protected unread mailbox
  assert_no_clobber_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !(pending_q[ok_idx] && protect_q[ok_idx]));
  // R5: a discarded frame leaves pending bits alone
  assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_full && !(wr_en && sel == SEL_PEND_CLR)) |=> $stable(pending_q));
  // R9: a discard raises the interrupt
  assert_drop_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_full && !(wr_en && sel == SEL_LOST_CLR)) |=> irq_lost);
endmodule

// File: tb/test_rx_mailbox_alloc.sv
module test_rx_mailbox_alloc;
  localparam int PERIOD = 10;
  localparam int NMB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ready, rx_ext = 1'b0, rx_rtr = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [31:0] rx_dlo = '0, rx_dhi = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [4:0]  wr_mb = '0, rd_mb = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_id, rd_ctrl, rd_dlo, rd_dhi;
  logic [NMB-1:0] pending, lost;
  logic        irq_lost;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_mailbox_alloc #(.NUM_MB(NMB)) i_rx_mailbox_alloc (
    .clk, .rst_n, .rx_valid, .rx_ready, .rx_ext, .rx_id, .rx_rtr, .rx_dlc,
    .rx_dlo, .rx_dhi, .wr_en, .wr_sel, .wr_mb, .wr_data, .rd_mb,
    .rd_id, .rd_ctrl, .rd_dlo, .rd_dhi, .pending, .lost, .irq_lost);

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [4:0] m, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_mb = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic e, input logic [28:0] id, input logic r,
                      input logic [3:0] dl, input logic [31:0] lo, input logic [31:0] hi);
    rx_valid = 1'b1; rx_ext = e; rx_id = id; rx_rtr = r; rx_dlc = dl;
    rx_dlo = lo; rx_dhi = hi;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic catch_all_bank(input logic [31:0] en, input logic [31:0] prot);
    for (int m = 16; m < NMB; m++) begin
      wr(3'd4, 5'(m), 32'h4000_0000);
      wr(3'd5, 5'(m), 32'hFFFF_FFFF);
    end
    wr(3'd0, 0, en);
    wr(3'd1, 0, prot);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 pending", pending, 0);
    chk("R12 lost", lost, 0);
    chk("R12 irq", 32'(irq_lost), 0);
    chk("R12 ready", 32'(rx_ready), 1);
  endtask

  task automatic t_highest_order();
    do_reset();
    catch_all_bank(32'hFFFF_0000, 32'hFFFF_FFFF);
    send(1'b0, 29'h123, 1'b1, 4'd8, 32'h1122_3344, 32'h5566_7788);
    chk("R1 first lands in 31", pending, 32'h8000_0000);
    rd_mb = 5'd31; #1;
    chk("R2 std id word", rd_id, 32'h048C_0000);
    chk("R2 ctrl rtr+dlc", rd_ctrl, 32'h18);
    chk("R2 data lo", rd_dlo, 32'h1122_3344);
    chk("R2 data hi", rd_dhi, 32'h5566_7788);
    send(1'b1, 29'h123_4567, 1'b0, 4'd3, 32'hA0A0_A0A0, 32'h0);
    chk("R4 second skips full 31", pending, 32'hC000_0000);
    rd_mb = 5'd30; #1;
    chk("R2 ext id word", rd_id, 32'h8123_4567);
    chk("R2 ctrl dlc", rd_ctrl, 32'h3);
    chk("R4 no lost", lost, 0);
  endtask

  task automatic t_all_full();
    do_reset();
    catch_all_bank(32'hC000_0000, 32'hFFFF_FFFF);
    send(1'b0, 29'h1, 1'b0, 4'd1, 32'h1111_1111, 0);
    send(1'b0, 29'h2, 1'b0, 4'd1, 32'h2222_2222, 0);
    send(1'b0, 29'h3, 1'b0, 4'd1, 32'h3333_3333, 0);
    chk("R5 pending unchanged", pending, 32'hC000_0000);
    chk("R5 lost on highest", lost, 32'h8000_0000);
    chk("R9 irq high", 32'(irq_lost), 1);
    rd_mb = 5'd31; #1;
    chk("R5 31 kept", rd_dlo, 32'h1111_1111);
    rd_mb = 5'd30; #1;
    chk("R5 30 kept", rd_dlo, 32'h2222_2222);
    wr(3'd3, 0, 32'h8000_0000);
    chk("R9 lost cleared", lost, 0);
    chk("R9 irq low", 32'(irq_lost), 0);
    wr(3'd2, 0, 32'h0);
    chk("R3 zero write no effect", pending, 32'hC000_0000);
    wr(3'd2, 0, 32'h4000_0000);
    chk("R3 clear one bit", pending, 32'h8000_0000);
  endtask

  task automatic t_enable();
    do_reset();
    catch_all_bank(32'h7FFF_0000, 32'hFFFF_FFFF);
    send(1'b0, 29'h5, 1'b0, 4'd2, 32'h5, 0);
    chk("R8 disabled 31 skipped", pending, 32'h4000_0000);
    wr(3'd0, 0, 32'hFFFF_0000);
    send(1'b0, 29'h6, 1'b0, 4'd2, 32'h6, 0);
    chk("R8 re-enabled 31 used", pending, 32'hC000_0000);
  endtask

  task automatic t_overwrite();
    do_reset();
    catch_all_bank(32'h8000_0000, 32'h0);
    send(1'b0, 29'h7, 1'b0, 4'd4, 32'h7777_7777, 0);
    chk("R6 first stored", pending, 32'h8000_0000);
    chk("R6 no lost yet", lost, 0);
    send(1'b0, 29'h8, 1'b0, 4'd4, 32'hAAAA_AAAA, 0);
    rd_mb = 5'd31; #1;
    chk("R6 overwritten", rd_dlo, 32'hAAAA_AAAA);
    chk("R6 lost set", lost, 32'h8000_0000);
  endtask

  task automatic t_mask();
    do_reset();
    wr(3'd4, 5'd5, 32'hDABC_DE00);
    wr(3'd5, 5'd5, 32'h0000_00FF);
    wr(3'd4, 5'd4, 32'h1FFC_0000);
    wr(3'd5, 5'd4, 32'hFFFF_FFFF);
    wr(3'd0, 0, 32'h0000_0030);
    send(1'b1, 29'h1ABC_DE55, 1'b0, 4'd1, 0, 0);
    chk("R7 masked low bits hit 5", pending, 32'h20);
    send(1'b1, 29'h1ABC_DF00, 1'b0, 4'd1, 0, 0);
    chk("R10 no match pending", pending, 32'h20);
    chk("R10 no match lost", lost, 0);
    send(1'b0, 29'h7FF, 1'b0, 4'd1, 0, 0);
    chk("R7 exact std hit 4", pending, 32'h30);
    wr(3'd2, 0, 32'h10);
    send(1'b1, 29'h1FFC_0000, 1'b0, 4'd1, 0, 0);
    chk("R7 format mismatch rejected", pending, 32'h20);
  endtask

  task automatic t_same_cycle();
    do_reset();
    catch_all_bank(32'h8000_0000, 32'h0);
    send(1'b0, 29'h9, 1'b0, 4'd1, 0, 0);
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h8000_0000;
    rx_valid = 1'b1; rx_id = 29'hA;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    chk("R11 store beats clear", pending, 32'h8000_0000);
    wr(3'd2, 0, 32'h8000_0000);
    chk("R3 plain clear", pending, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_highest_order();
    t_all_full();
    t_enable();
    t_overwrite();
    t_mask();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule